// File: doc/BRIEF.md
# Adaptive FSK Period Demodulator

This block turns the digitized output of a limiter, carrying a two-tone FSK signal, into a bit stream and then into bytes. It counts system clocks between consecutive rising edges of the input, so every input period becomes one count. The carrier used for logic 0 (the higher tone) gives the shorter period. The block learns that period from the input itself. It averages eight consecutive periods that all fall inside a plausible window, and from then on it judges each period against that reference plus a hysteresis margin.

The decisions pass through a two-period glitch filter into a 12-entry history. When the history shows a run of eight short periods followed at once by four long ones, the block reports a start and then packs each later filtered decision into bytes. A host may bypass learning by supplying a fixed base count. Holding `enable` low clears the block and makes it ready for the next reception.

Top module: `fsk_period_demod`

## Requirements
- R1: While `enable` is high, each rising edge of `lim_in` after the first ends one measurement, whose count is the number of clock cycles since the previous rising edge. The first rising edge after `enable` rises gives no measurement. With `enable` low, all outputs and learned state read 0.
- R2: The period count saturates at 255. A longer period is treated as 255 and is never reduced modulo 256.
- R3: A count is in range when 112 <= count <= 125. An out-of-range count while learning discards every in-range count collected so far.
- R4: After eight consecutive in-range counts, `avg_count` shows floor(sum/8) and `ref_valid` goes high. Both hold until `enable` falls.
- R5: Classification begins with the first period after `ref_valid` rises. The period that completes learning is not classified.
- R6: The base is `avg_count`, or `fix_thr` when overridden. If the previous raw decision was low (its initial value), a count is high when count > base+7. If it was high, the count stays high when count > base+5.
- R7: The filtered decision takes the raw decision only when that decision equals the raw decision of the previous classified period. Otherwise it keeps its old value. Both start low.
- R8: Filtered decisions enter a 12-entry history. `start_det` pulses for one cycle, once per enable session, when the 12 most recent entries are eight lows followed by four highs, the newest last.
- R9: After the start, each classified period supplies one bit (high decision = 1). Bits are packed least significant bit first, and `byte_valid` pulses for one cycle with `byte_data` after every eighth bit.
- R10: With `fix_en` high, `fix_thr` is the base and classification does not wait for `ref_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Measure/receive enable. Low clears the block |
| lim_in | input | 1 | Digitized limiter signal |
| fix_en | input | 1 | Use `fix_thr` as the decision base |
| fix_thr | input | 8 | Fixed base count |
| avg_count | output | 8 | Learned low-bit period count |
| ref_valid | output | 1 | Reference learned |
| start_det | output | 1 | Start pattern found (pulse) |
| byte_valid | output | 1 | Byte ready (pulse) |
| byte_data | output | 8 | Assembled byte, first bit in bit 0 |

## Verification
The bench sweeps every in-range period and the two counts just outside the window. A window bound off by one would then either accept 111 or 126 or reject an edge value. Runs broken by one out-of-range count must not be half-averaged. Periods of exactly base+7, and decisions that fall back through base+5, expose a design that uses one threshold or swaps the two. A single-period reversal inside the low-to-high transition catches a missing filter, because the start pattern is then never seen. A 400-cycle period against a fixed base of 200 catches a counter that wraps instead of saturating, since the wrapped value reads as a short period.

// File: rtl/fsk_demod_pkg.sv
package fsk_demod_pkg;
  localparam int unsigned PER_W  = 8;
  localparam int unsigned AVG_LG = 3;

  typedef logic [PER_W-1:0] per_t;

  typedef struct packed {
    logic vld;
    per_t cnt;
  } period_s;
endpackage

// File: rtl/fsk_period_meter.sv
module fsk_period_meter
  import fsk_demod_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    enable,
  input  logic    lim_in,
  output period_s per_o
);
  localparam per_t CNT_MAX = '1;

  logic lim_q, lim_qq, armed_q;
  per_t cnt_q;
  logic rise;

  assign rise = lim_q & ~lim_qq;

  always_ff @(posedge clk) begin
    if (rst) begin
      lim_q   <= 1'b0;
      lim_qq  <= 1'b0;
      armed_q <= 1'b0;
      cnt_q   <= '0;
      per_o   <= '0;
    end else begin
      lim_q     <= lim_in;
      lim_qq    <= lim_q;
      per_o.vld <= 1'b0;
      if (!enable) begin
        cnt_q   <= '0;
        armed_q <= 1'b0;
        per_o   <= '0;
      end else if (rise) begin
        per_o.vld <= armed_q;
        per_o.cnt <= cnt_q;
        cnt_q     <= per_t'(1);
        armed_q   <= 1'b1;
      end else if (cnt_q != CNT_MAX) begin
        cnt_q <= cnt_q + per_t'(1);
      end
    end
  end

  // R1
  nonzero_period_chk: assert property (@(posedge clk) disable iff (rst)
    per_o.vld |-> per_o.cnt != '0);

  // R1
  quiet_when_off_chk: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !per_o.vld);
endmodule

// File: rtl/fsk_ref_learner.sv
module fsk_ref_learner
  import fsk_demod_pkg::*;
#(
  parameter per_t LO_MIN = 8'd112,
  parameter per_t LO_MAX = 8'd125
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    enable,
  input  period_s per_i,
  output per_t    ref_o,
  output logic    valid_o
);
  localparam int unsigned SUM_W = PER_W + AVG_LG;

  logic [SUM_W-1:0]  sum_q, sum_nx;
  logic [AVG_LG-1:0] n_q;
  logic              in_rng;

  assign in_rng = (per_i.cnt >= LO_MIN) && (per_i.cnt <= LO_MAX);
  assign sum_nx = sum_q + SUM_W'(per_i.cnt);

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      sum_q   <= '0;
      n_q     <= '0;
      ref_o   <= '0;
      valid_o <= 1'b0;
    end else if (per_i.vld && !valid_o) begin
      if (!in_rng) begin
        sum_q <= '0;
        n_q   <= '0;
      end else if (n_q == '1) begin
        ref_o   <= sum_nx[SUM_W-1:AVG_LG];
        valid_o <= 1'b1;
        sum_q   <= '0;
        n_q     <= '0;
      end else begin
        sum_q <= sum_nx;
        n_q   <= n_q + 1'b1;
      end
    end
  end

  // R4
  ref_in_window_chk: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> (ref_o >= LO_MIN && ref_o <= LO_MAX));

  // R4
  ref_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_o && enable) |=> valid_o);
endmodule

// File: rtl/fsk_bit_slicer.sv
module fsk_bit_slicer
  import fsk_demod_pkg::*;
#(
  parameter int unsigned HYS_UP  = 7,
  parameter int unsigned HYS_DN  = 5,
  parameter int unsigned HIST_W  = 12,
  parameter int unsigned LEAD_LO = 8,
  parameter int unsigned BYTE_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  period_s           per_i,
  input  per_t              base_i,
  input  logic              cls_en_i,
  output logic              start_o,
  output logic              byte_vld_o,
  output logic [BYTE_W-1:0] byte_o
);
  localparam int unsigned HIGH_N = HIST_W - LEAD_LO;
  localparam logic [HIST_W-1:0] START_PAT = HIST_W'((1 << HIGH_N) - 1);
  localparam int unsigned FILL_W = $clog2(HIST_W + 1);
  localparam int unsigned BC_W   = $clog2(BYTE_W);
  localparam logic [PER_W:0] UP_M = (PER_W+1)'(HYS_UP);
  localparam logic [PER_W:0] DN_M = (PER_W+1)'(HYS_DN);

  logic              hi_q, rp_q, f_q, lock_q;
  logic [HIST_W-1:0] hist_q, hist_nx;
  logic [FILL_W-1:0] fill_q;
  logic [BC_W-1:0]   bc_q;
  logic [BYTE_W-1:0] sh_q;
  logic [PER_W:0]    thr;
  logic              raw, f_nx;

  always_comb begin
    thr     = {1'b0, base_i} + (hi_q ? DN_M : UP_M);
    raw     = {1'b0, per_i.cnt} > thr;
    f_nx    = (raw == rp_q) ? raw : f_q;
    hist_nx = {hist_q[HIST_W-2:0], f_nx};
  end

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      hi_q <= 1'b0; rp_q <= 1'b0; f_q <= 1'b0; lock_q <= 1'b0;
      hist_q <= '0; fill_q <= '0; bc_q <= '0; sh_q <= '0;
      start_o <= 1'b0; byte_vld_o <= 1'b0; byte_o <= '0;
    end else begin
      start_o    <= 1'b0;
      byte_vld_o <= 1'b0;
      if (per_i.vld && cls_en_i) begin
        hi_q   <= raw;
        rp_q   <= raw;
        f_q    <= f_nx;
        hist_q <= hist_nx;
        if (fill_q != FILL_W'(HIST_W)) fill_q <= fill_q + 1'b1;
        if (!lock_q) begin
          if (fill_q >= FILL_W'(HIST_W - 1) && hist_nx == START_PAT) begin
            start_o <= 1'b1;
            lock_q  <= 1'b1;
            bc_q    <= '0;
          end
        end else begin
          sh_q <= {f_nx, sh_q[BYTE_W-1:1]};
          if (bc_q == BC_W'(BYTE_W - 1)) begin
            byte_o     <= {f_nx, sh_q[BYTE_W-1:1]};
            byte_vld_o <= 1'b1;
            bc_q       <= '0;
          end else begin
            bc_q <= bc_q + 1'b1;
          end
        end
      end
    end
  end

  // R8
  start_once_chk: assert property (@(posedge clk) disable iff (rst)
    start_o |=> !start_o);

  // R9
  byte_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    byte_vld_o |=> !byte_vld_o);

  // R9
  byte_not_with_start_chk: assert property (@(posedge clk) disable iff (rst)
    byte_vld_o |-> !start_o);
endmodule

// File: rtl/fsk_period_demod.sv
module fsk_period_demod
  import fsk_demod_pkg::*;
#(
  parameter per_t        LO_MIN  = 8'd112,
  parameter per_t        LO_MAX  = 8'd125,
  parameter int unsigned HYS_UP  = 7,
  parameter int unsigned HYS_DN  = 5,
  parameter int unsigned HIST_W  = 12,
  parameter int unsigned LEAD_LO = 8,
  parameter int unsigned BYTE_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              lim_in,
  input  logic              fix_en,
  input  logic [PER_W-1:0]  fix_thr,
  output logic [PER_W-1:0]  avg_count,
  output logic              ref_valid,
  output logic              start_det,
  output logic              byte_valid,
  output logic [BYTE_W-1:0] byte_data
);
  period_s per;
  per_t    base;
  logic    cls_en;

  fsk_period_meter u_meter (
    .clk(clk), .rst(rst), .enable(enable), .lim_in(lim_in), .per_o(per)
  );

  fsk_ref_learner #(.LO_MIN(LO_MIN), .LO_MAX(LO_MAX)) u_learn (
    .clk(clk), .rst(rst), .enable(enable), .per_i(per),
    .ref_o(avg_count), .valid_o(ref_valid)
  );

  assign base   = fix_en ? fix_thr : avg_count;
  assign cls_en = fix_en | ref_valid;

  fsk_bit_slicer #(
    .HYS_UP(HYS_UP), .HYS_DN(HYS_DN), .HIST_W(HIST_W),
    .LEAD_LO(LEAD_LO), .BYTE_W(BYTE_W)
  ) u_slice (
    .clk(clk), .rst(rst), .enable(enable), .per_i(per),
    .base_i(base), .cls_en_i(cls_en),
    .start_o(start_det), .byte_vld_o(byte_valid), .byte_o(byte_data)
  );
endmodule

// File: tb/tb_fsk_period_demod.sv
module tb_fsk_period_demod;
  logic clk = 1'b0, rst = 1'b1, enable = 1'b0, lim_in = 1'b0, fix_en = 1'b0;
  logic [7:0] fix_thr = 8'd0;
  logic [7:0] avg_count, byte_data;
  logic ref_valid, start_det, byte_valid;

  always #10 clk = ~clk;

  fsk_period_demod dut (
    .clk(clk), .rst(rst), .enable(enable), .lim_in(lim_in), .fix_en(fix_en),
    .fix_thr(fix_thr), .avg_count(avg_count), .ref_valid(ref_valid),
    .start_det(start_det), .byte_valid(byte_valid), .byte_data(byte_data)
  );

  int errors = 0, checks = 0;
  int obs_starts = 0, obs_n = 0;
  logic [7:0] obs_bytes [64];
  // independent model of the requirements
  int m_sum, m_n, m_ref, m_starts, m_bn, m_bc, m_fill, m_last;
  bit m_valid, m_hi, m_rp, m_f, m_lock, m_have, m_fix;
  int m_thr;
  logic [11:0] m_sr;
  logic [7:0]  m_byte;
  logic [7:0]  exp_bytes [64];

  always @(negedge clk) begin
    if (start_det) obs_starts++;
    if (byte_valid && obs_n < 64) begin obs_bytes[obs_n] = byte_data; obs_n++; end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_step(int p);
    int pc, base;
    bit cls, raw, fn;
    pc  = (p > 255) ? 255 : p;
    cls = m_fix || m_valid;
    if (cls) begin
      base = m_fix ? m_thr : m_ref;
      raw  = pc > base + (m_hi ? 5 : 7);
      m_hi = raw;
      fn   = (raw == m_rp) ? raw : m_f;
      m_rp = raw; m_f = fn;
      m_sr = {m_sr[10:0], fn};
      if (m_fill < 12) m_fill++;
      if (!m_lock) begin
        if (m_fill >= 12 && m_sr == 12'h00F) begin m_starts++; m_lock = 1; m_bc = 0; end
      end else begin
        m_byte = {fn, m_byte[7:1]};
        m_bc++;
        if (m_bc == 8) begin exp_bytes[m_bn] = m_byte; m_bn++; m_bc = 0; end
      end
    end
    if (!m_valid) begin
      if (pc >= 112 && pc <= 125) begin
        m_sum += pc; m_n++;
        if (m_n == 8) begin m_ref = m_sum / 8; m_valid = 1; end
      end else begin
        m_sum = 0; m_n = 0;
      end
    end
  endtask

  task automatic send_period(int p);
    if (m_have) model_step(m_last);
    m_have = 1; m_last = p;
    lim_in = 1'b1;
    repeat (p / 2) @(negedge clk);
    lim_in = 1'b0;
    repeat (p - p / 2) @(negedge clk);
  endtask

  task automatic send_n(int n, int p);
    for (int i = 0; i < n; i++) send_period(p);
  endtask

  task automatic begin_session(bit fx, int thr);
    @(negedge clk);
    enable = 1'b0; lim_in = 1'b0; fix_en = fx; fix_thr = 8'(thr);
    repeat (4) @(negedge clk);
    m_sum = 0; m_n = 0; m_ref = 0; m_valid = 0; m_hi = 0; m_rp = 0; m_f = 0;
    m_sr = '0; m_fill = 0; m_lock = 0; m_bc = 0; m_bn = 0; m_byte = '0;
    m_starts = 0; m_have = 0; m_fix = fx; m_thr = thr;
    obs_starts = 0; obs_n = 0;
    enable = 1'b1;
    @(negedge clk);
  endtask

  task automatic end_session();
    send_period(120);
    repeat (6) @(negedge clk);
  endtask

  task automatic cmp_model(string req);
    chk(obs_starts == m_starts, req, obs_starts, m_starts);
    chk(obs_n == m_bn, req, obs_n, m_bn);
    for (int i = 0; i < m_bn && i < obs_n; i++)
      chk(obs_bytes[i] == exp_bytes[i], req, obs_bytes[i], exp_bytes[i]);
  endtask

  task automatic learn_and_lead(int p);
    send_n(8, p);   // learning periods
    send_n(8, p);   // classified low periods
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(avg_count == 0 && !ref_valid && !start_det && !byte_valid, "R1 reset",
        {ref_valid, start_det, byte_valid}, 0);

    // R3 R4 sweep over every in-range period
    for (int p = 112; p <= 125; p++) begin
      begin_session(0, 0);
      send_n(8, p);
      end_session();
      chk(ref_valid == 1'b1, "R4 valid", ref_valid, 1);
      chk(avg_count == 8'(p), "R4 avg", avg_count, p);
    end
    // R1 enable low clears learned state
    @(negedge clk); enable = 1'b0; repeat (3) @(negedge clk);
    chk(!ref_valid && avg_count == 0, "R1 clear", avg_count, 0);

    // R3 just outside the window
    begin_session(0, 0); send_n(8, 111); end_session();
    chk(ref_valid == 1'b0, "R3 below", ref_valid, 0);
    begin_session(0, 0); send_n(8, 126); end_session();
    chk(ref_valid == 1'b0, "R3 above", ref_valid, 0);

    // R4 mixed average 112..119 -> 115
    begin_session(0, 0);
    for (int p = 112; p <= 119; p++) send_period(p);
    end_session();
    chk(avg_count == 8'd115, "R4 mixed", avg_count, 115);

    // R3 interruption discards partial run
    begin_session(0, 0);
    send_n(7, 120); send_period(126); send_n(7, 120);
    end_session();
    chk(ref_valid == 1'b0, "R3 discard", ref_valid, 0);
    begin_session(0, 0);
    send_n(7, 118); send_period(126); send_n(8, 122);
    end_session();
    chk(ref_valid && avg_count == 8'd122, "R3 rerun", avg_count, 122);

    // R6 exactly base+7 is not high: no start
    begin_session(0, 0); learn_and_lead(119); send_n(6, 126); end_session();
    chk(obs_starts == 0, "R6 edge", obs_starts, 0);
    cmp_model("R6 model");

    // R8 R5 start on base+8
    begin_session(0, 0); learn_and_lead(119); send_n(5, 127); end_session();
    chk(obs_starts == 1, "R8 start", obs_starts, 1);
    cmp_model("R8 model");

    // R6 R9 hysteresis on the way back: bits 1,1,1,1,1,0,0,0 -> 0x1F
    begin_session(0, 0); learn_and_lead(119); send_n(5, 127);
    send_n(4, 125); send_n(4, 124); end_session();
    chk(obs_n == 1 && obs_bytes[0] == 8'h1F, "R9 hyst byte", obs_bytes[0], 8'h1F);
    cmp_model("R6 model");

    // R7 non-monotonic transition still yields a start
    begin_session(0, 0); learn_and_lead(119);
    send_period(127); send_period(119); send_n(5, 127); end_session();
    chk(obs_starts == 1, "R7 filter", obs_starts, 1);
    cmp_model("R7 model");

    // R9 data bytes 0xA5, 0x3C
    begin_session(0, 0); learn_and_lead(117); send_n(5, 127);
    for (int b = 0; b < 16; b++) begin
      logic [15:0] d = 16'h3CA5;
      send_period(d[b] ? 131 : 117);
    end
    end_session();
    chk(obs_n == 2, "R9 count", obs_n, 2);
    cmp_model("R9 model");

    // R10 R2 fixed base, long periods saturate rather than wrap
    begin_session(1, 200); send_n(9, 150); send_n(5, 400); end_session();
    chk(ref_valid == 1'b0, "R10 no ref", ref_valid, 0);
    chk(obs_starts == 1, "R2 saturate", obs_starts, 1);
    cmp_model("R10 model");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule